// File: doc/BRIEF.md
# Card Initialization Clock Sequencer

This block produces the clock burst that a memory card needs after power-up, before it will accept its first command. Software sets an init-mode bit in a control register and then writes the command register. The block does not send a command. It runs a fixed number of card clock periods while the command line stays idle-high. When the burst finishes, it sets a command-complete status bit.

A burst starts only if the power state has moved into "on" since the last burst. Holding power on and repeating the write does not start a second burst. A watchdog stops a burst that runs longer than a set number of system cycles and sets a timeout status bit instead. Both status bits are cleared by writing 1 to them. The interrupt output stays low while a burst runs and while init mode is still set.

Top module: `init_clk_seq`

## Requirements
- R1: After reset these outputs are low: card clock, busy, init mode, command-complete, timeout and interrupt. The command line is high.
- R2: The control register is at byte offset 0x00. Bit 1 is the init-mode bit and is shown on `init_mode_o`. Bits [25:16] hold the divisor `d`.
- R3: A burst starts when the command register (byte offset 0x04) is written while init mode is set, the block is armed and no burst is running. `busy_o` is high from the cycle after that write.
- R4: During a burst the card clock starts low and each half period lasts `d+1` system cycles. It produces exactly NUM_CLKS rising edges and ends low. Command-complete rises, and busy falls, 2*NUM_CLKS*(d+1) cycles after busy rises.
- R5: `card_cmd_o` is held high at all times.
- R6: The block arms when `power_on_i` rises. It disarms when `power_on_i` goes low or when a burst starts. A command write while disarmed, even with power on, starts nothing.
- R7: A command write with init mode clear starts nothing. It does not disarm the block.
- R8: A command write during a running burst is ignored. The burst keeps its original length.
- R9: The status register is at byte offset 0x08. Bit 0 is command-complete and bit 1 is timeout. Writing 1 to a bit clears it. Writing 0 leaves it unchanged.
- R10: If a burst has not finished after TIMEOUT_CYCLES cycles of busy, it is aborted. Busy falls and the card clock goes low. The timeout bit sets and command-complete does not.
- R11: `irq_o` is high when a status bit is set, no burst is running and init mode is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| power_on_i | input | 1 | Card power state is "on" |
| init_mode_o | output | 1 | Current init-mode bit |
| busy_o | output | 1 | Burst running |
| card_clk_o | output | 1 | Card clock |
| card_cmd_o | output | 1 | Card command line |
| cc_o | output | 1 | Command-complete status |
| tmo_o | output | 1 | Timeout status |
| irq_o | output | 1 | Interrupt to the host |

## Verification
The hardest case to reach from the ports is the watchdog abort. A correct burst always finishes, so the timeout path runs only when the burst is longer than the timeout window. The bench builds the block with a short timeout window and sets a large divisor, so the burst would need more cycles than the window allows. A second hard case is the re-arm rule. A power-off and power-on pulse is followed first by a write with init mode clear, then by a real start. This shows that the ignored write did not use up the arming.

// File: rtl/init_clk_seq_pkg.sv
package init_clk_seq_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 32;
  localparam logic [ADDR_W-1:0] OFS_CTRL = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_CMD  = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_STAT = 8'h08;
  localparam int unsigned INIT_BIT = 1;
  localparam int unsigned DIV_LSB  = 16;
  localparam int unsigned CC_BIT   = 0;
  localparam int unsigned TMO_BIT  = 1;

  typedef enum logic [1:0] {SEL_NONE, SEL_CTRL, SEL_CMD, SEL_STAT} reg_sel_e;
endpackage

// File: rtl/init_regs.sv
module init_regs
  import init_clk_seq_pkg::*;
#(
  parameter int unsigned DIV_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              done_i,
  input  logic              expire_i,
  output logic              init_o,
  output logic [DIV_W-1:0]  div_o,
  output logic              cmd_wr_o,
  output logic              cc_o,
  output logic              tmo_o
);
  reg_sel_e sel;
  always_comb begin
    sel = SEL_NONE;
    if (we_i) begin
      unique case (addr_i)
        OFS_CTRL: sel = SEL_CTRL;
        OFS_CMD:  sel = SEL_CMD;
        OFS_STAT: sel = SEL_STAT;
        default:  sel = SEL_NONE;
      endcase
    end
  end

  assign cmd_wr_o = (sel == SEL_CMD);

  logic unused_wdata;
  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_o <= 1'b0;
      div_o  <= '0;
    end else if (sel == SEL_CTRL) begin
      init_o <= wdata_i[INIT_BIT];
      div_o  <= wdata_i[DIV_LSB +: DIV_W];
    end
  end

  // hardware set wins over a same-cycle W1C
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cc_o  <= 1'b0;
      tmo_o <= 1'b0;
    end else begin
      if (done_i) cc_o <= 1'b1;
      else if (sel == SEL_STAT && wdata_i[CC_BIT]) cc_o <= 1'b0;
      if (expire_i) tmo_o <= 1'b1;
      else if (sel == SEL_STAT && wdata_i[TMO_BIT]) tmo_o <= 1'b0;
    end
  end
endmodule

// File: rtl/init_clkgen.sv
module init_clkgen #(
  parameter int unsigned NUM_CLKS = 74,
  parameter int unsigned DIV_W    = 10,
  localparam int unsigned CNT_W   = $clog2(NUM_CLKS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             abort_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             busy_o,
  output logic             card_clk_o,
  output logic             done_o
);
  logic [DIV_W-1:0] div_q, hcnt_q;
  logic [CNT_W-1:0] rise_q;
  logic             hit;

  assign hit    = (hcnt_q == div_q);
  // final falling toggle after the last rising edge
  assign done_o = busy_o & hit & card_clk_o & (rise_q == CNT_W'(NUM_CLKS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o     <= 1'b0;
      card_clk_o <= 1'b0;
      div_q      <= '0;
      hcnt_q     <= '0;
      rise_q     <= '0;
    end else if (abort_i) begin
      busy_o     <= 1'b0;
      card_clk_o <= 1'b0;
      hcnt_q     <= '0;
      rise_q     <= '0;
    end else if (start_i) begin
      busy_o     <= 1'b1;
      card_clk_o <= 1'b0;
      div_q      <= div_i;
      hcnt_q     <= '0;
      rise_q     <= '0;
    end else if (busy_o) begin
      if (hit) begin
        hcnt_q     <= '0;
        card_clk_o <= ~card_clk_o;
        if (!card_clk_o) rise_q <= rise_q + 1'b1;
        if (done_o) busy_o <= 1'b0;
      end else begin
        hcnt_q <= hcnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/init_watchdog.sv
module init_watchdog #(
  parameter int unsigned TIMEOUT_CYCLES = 250000,
  localparam int unsigned TMO_W         = $clog2(TIMEOUT_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic busy_i,
  input  logic done_i,
  output logic expire_o
);
  logic [TMO_W-1:0] cnt_q;

  assign expire_o = busy_i & ~done_i & (cnt_q == TMO_W'(TIMEOUT_CYCLES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (start_i)           cnt_q <= '0;
    else if (busy_i && !done_i) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/init_clk_seq.sv
module init_clk_seq
  import init_clk_seq_pkg::*;
#(
  parameter int unsigned NUM_CLKS       = 74,
  parameter int unsigned DIV_W          = 10,
  parameter int unsigned TIMEOUT_CYCLES = 250000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [7:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  input  logic        power_on_i,
  output logic        init_mode_o,
  output logic        busy_o,
  output logic        card_clk_o,
  output logic        card_cmd_o,
  output logic        cc_o,
  output logic        tmo_o,
  output logic        irq_o
);
  logic [DIV_W-1:0] div;
  logic cmd_wr, done, expire, start;
  logic pwr_q, armed_q;

  init_regs #(.DIV_W(DIV_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .done_i(done), .expire_i(expire),
    .init_o(init_mode_o), .div_o(div), .cmd_wr_o(cmd_wr),
    .cc_o(cc_o), .tmo_o(tmo_o)
  );

  assign start = cmd_wr & init_mode_o & armed_q & ~busy_o;

  // arm on entry into power-on; one burst per entry
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pwr_q   <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      pwr_q <= power_on_i;
      if (!power_on_i || start)   armed_q <= 1'b0;
      else if (!pwr_q)            armed_q <= 1'b1;
    end
  end

  init_clkgen #(.NUM_CLKS(NUM_CLKS), .DIV_W(DIV_W)) u_clkgen (
    .clk_i, .rst_ni,
    .start_i(start), .abort_i(expire), .div_i(div),
    .busy_o(busy_o), .card_clk_o(card_clk_o), .done_o(done)
  );

  init_watchdog #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_wdog (
    .clk_i, .rst_ni,
    .start_i(start), .busy_i(busy_o), .done_i(done), .expire_o(expire)
  );

  assign card_cmd_o = 1'b1;
  assign irq_o      = (cc_o | tmo_o) & ~busy_o & ~init_mode_o;
endmodule

// File: rtl/init_clk_seq_chk.sv
module init_clk_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic power_on_i,
  input logic init_mode_o,
  input logic busy_o,
  input logic card_clk_o,
  input logic cc_o,
  input logic tmo_o,
  input logic irq_o
);
  assert_cc_ends_burst_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cc_o) |-> $fell(busy_o));
  assert_idle_clk_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> !card_clk_o);
  assert_start_needs_init_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(init_mode_o));
  assert_start_needs_power_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(power_on_i));
  assert_tmo_no_cc_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tmo_o) |-> (!$rose(cc_o) && $fell(busy_o)));
  assert_irq_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o || init_mode_o) |-> !irq_o);
endmodule

bind init_clk_seq init_clk_seq_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .power_on_i(power_on_i),
  .init_mode_o(init_mode_o), .busy_o(busy_o), .card_clk_o(card_clk_o),
  .cc_o(cc_o), .tmo_o(tmo_o), .irq_o(irq_o)
);

// File: tb/init_clk_seq_tb.sv
module init_clk_seq_tb;
  localparam int NUM = 74;
  localparam int TMO = 2000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic we = 1'b0, pwr = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0;
  logic init_mode, busy, card_clk, card_cmd, cc, tmo, irq;

  always #2 clk = ~clk;

  init_clk_seq #(.NUM_CLKS(NUM), .TIMEOUT_CYCLES(TMO)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .power_on_i(pwr), .init_mode_o(init_mode),
    .busy_o(busy), .card_clk_o(card_clk), .card_cmd_o(card_cmd),
    .cc_o(cc), .tmo_o(tmo), .irq_o(irq)
  );

  int checks = 0, fails = 0, cyc = 0;
  typedef struct {bit is_tmo; int at;} exp_t;
  exp_t exp_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  function automatic logic [31:0] ctrl(input bit ini, input int dv);
    return (32'(dv) << 16) | (ini ? 32'h2 : 32'h0);
  endfunction

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pwr_cycle();
    @(negedge clk); pwr = 1'b0; idle(3); pwr = 1'b1; idle(3);
  endtask

  // driver: start a burst and queue the expected completion
  task automatic burst(input int dv, input bit expect_tmo);
    exp_t e;
    wr(8'h04, 32'h0);
    chk(busy == 1'b1, "R3 busy after cmd write", busy, 1);
    e.is_tmo = expect_tmo;
    e.at = expect_tmo ? cyc + TMO : cyc + 2 * NUM * (dv + 1);
    exp_q.push_back(e);
  endtask

  // monitor
  logic cc_p = 1'b0, tmo_p = 1'b0, clk_p = 1'b0;
  int rises = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (card_clk && !clk_p) rises++;
      if ((cc && !cc_p) || (tmo && !tmo_p)) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R4 unexpected completion", cyc, -1);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk((tmo && !tmo_p) == e.is_tmo, "R10 completion kind", int'(tmo && !tmo_p), int'(e.is_tmo));
          chk(cyc == e.at, e.is_tmo ? "R10 timeout cycle" : "R4 completion cycle", cyc, e.at);
          if (!e.is_tmo) chk(rises == NUM, "R4 card clock rises", rises, NUM);
          chk(!busy && !card_clk, "R4 idle after burst", int'({busy, card_clk}), 0);
          chk(card_cmd == 1'b1, "R5 cmd line high", card_cmd, 1);
        end
        rises = 0;
      end
      cc_p <= cc; tmo_p <= tmo; clk_p <= card_clk;
    end
  end

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    idle(2);
  endtask

  initial begin
    fork
      begin
        idle(100000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    join_none

    idle(3);
    chk({card_clk, busy, init_mode, cc, tmo, irq} == 6'b0, "R1 reset outputs",
        int'({card_clk, busy, init_mode, cc, tmo, irq}), 0);
    chk(card_cmd == 1'b1, "R1 cmd high in reset", card_cmd, 1);
    rst_n = 1'b1;
    idle(2);

    // first burst, divisor 0, with a re-trigger mid-burst
    wr(8'h00, ctrl(1, 0));
    chk(init_mode == 1'b1, "R2 init bit", init_mode, 1);
    pwr = 1'b1; idle(3);
    burst(0, 1'b0);
    idle(40);
    wr(8'h04, 32'h0); // R8 must be ignored
    drain();
    chk(cc == 1'b1, "R4 cc set", cc, 1);
    chk(irq == 1'b0, "R11 irq held while init set", irq, 0);

    // power still on: not re-armed
    wr(8'h04, 32'h0);
    idle(2);
    chk(busy == 1'b0, "R6 no burst without power transition", busy, 0);

    wr(8'h00, ctrl(0, 0));
    chk(irq == 1'b1, "R11 irq after init cleared", irq, 1);
    wr(8'h08, 32'h0);
    chk(cc == 1'b1, "R9 write 0 keeps cc", cc, 1);
    wr(8'h08, 32'h1);
    chk(cc == 1'b0 && irq == 1'b0, "R9 W1C clears cc", int'({cc, irq}), 0);

    // armed, init clear: ignored and arming kept
    pwr_cycle();
    wr(8'h04, 32'h0);
    idle(2);
    chk(busy == 1'b0, "R7 no burst with init clear", busy, 0);
    wr(8'h00, ctrl(1, 3));
    burst(3, 1'b0);
    drain();
    wr(8'h00, ctrl(0, 3));
    wr(8'h08, 32'h1);

    // long divisor hits the timeout
    pwr_cycle();
    wr(8'h00, ctrl(1, 20));
    burst(20, 1'b1);
    drain();
    chk(tmo == 1'b1 && cc == 1'b0, "R10 tmo set cc clear", int'({tmo, cc}), 2);
    chk(irq == 1'b0, "R11 irq held while init set", irq, 0);
    wr(8'h00, ctrl(0, 0));
    chk(irq == 1'b1, "R11 irq on timeout", irq, 1);
    wr(8'h08, 32'h2);
    chk(tmo == 1'b0 && irq == 1'b0, "R9 W1C clears tmo", int'({tmo, irq}), 0);
    chk(card_cmd == 1'b1, "R5 cmd line high", card_cmd, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule